// File: doc/BRIEF.md
# Seven-Channel DMA Start and Interrupt Register Block

This block holds the software-visible registers of a multi-channel DMA controller and turns software writes into transfer starts. Each channel has a base address, a block count and a control word. A global enable word gates each channel, and a global interrupt word carries both per-channel interrupt enables and completion flags. All registers are reached through a simple 32-bit register bus. Writes take effect at the clock edge, and reads are combinational from the current register contents.

A channel starts when its control word is written with bit 24 set while that channel's enable bit, bit (3 + 4·n), is set in the global enable word. The start is judged only at the moment of that write. The block then emits a single-cycle request that carries the channel number, base address and block count. The request is a plain pulse with no back-pressure: the external engine must take it in the cycle it appears.

When the engine pulses that channel's done input, the block clears bit 24 of the control word. If interrupt enable bit (16 + n) is set, it also sets completion flag (24 + n) and pulses the interrupt request output. Software clears flags by writing ones to bits 31:24 of the interrupt word.

Top module: `dmac_regs`

## Requirements
- R1: After reset every register reads 0, and `req_valid` and `irq_req` are 0.
- R2: Writes to a channel's base address (offset 0x80+0x10·n), block count (+4) or the global enable word (0xF0) store the value exactly, read back unchanged and produce no request.
- R3: A write to channel n's control word (+8) with bit 24 set, while global enable bit (3+4·n) is 1, makes `req_valid` high for exactly the one cycle after the write edge. In that cycle `req_chan`=n, and `req_addr` and `req_count` equal the channel's stored registers.
- R4: A control write with bit 24 set while the channel's enable bit is 0 produces no request, and the written value, bit 24 included, is stored.
- R5: A done pulse on channel n clears bit 24 of that channel's control word and keeps every other bit of it.
- R6: A done pulse on channel n while interrupt word bit (16+n) is 1 sets flag bit (24+n) and makes `irq_req` high for the one cycle after that edge.
- R7: A done pulse while bit (16+n) is 0 sets no flag and leaves `irq_req` low.
- R8: A write to the interrupt word (0xF4) loads bits 23:0 from the data. In bits 31:24, a bit written as 1 is cleared and a bit written as 0 keeps its value.
- R9: When a completion flag is set in the same cycle as an interrupt word write that would clear it, the flag ends set.
- R10: Reads of unmapped offsets (for example 0x00, 0x8C, 0xF8) return 0.
- R11: When channel n's control word is written in the same cycle as its done pulse, the written value is stored and the start rule of R3 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| done_i | input | 7 | Per-channel transfer-complete pulse |
| req_valid | output | 1 | One-cycle transfer request |
| req_chan | output | 3 | Channel of the request |
| req_addr | output | 32 | Base address of the requested channel |
| req_count | output | 32 | Block count of the requested channel |
| irq_req | output | 1 | One-cycle completion interrupt request |

## Verification
A channel's completion can land in the same cycle as a software write that acts on the same state. One case is a write-one-to-clear of the interrupt word; the other is a new write to that channel's control word. The bench provokes each case by raising a done bit and the write strobe in the same cycle. For the interrupt word, it judges that the flag ends set and that the interrupt pulse appears. For the control word, it judges that the written value survives and that a new request is issued.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH      = 7;
  localparam int DW       = 32;
  localparam int AW       = 8;
  localparam int CH_BASE  = 'h80;
  localparam int GEN_OFF  = 'hF0;
  localparam int ICR_OFF  = 'hF4;
  localparam int GO_BIT   = 24;
  localparam int IEN_LSB  = 16;
  localparam int FLG_LSB  = 24;
  localparam int CHW      = $clog2(NCH);
  typedef enum logic [1:0] {
    SLOT_ADDR = 2'd0,
    SLOT_CNT  = 2'd1,
    SLOT_CTL  = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int DW     = 32,
  parameter int GO_BIT = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  input  logic          done,
  input  logic          chan_en,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] ctl_q,
  output logic          start
);
  assign start = wr_ctl & wdata[GO_BIT] & chan_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
    end else begin
      if (wr_addr) addr_q <= wdata;
      if (wr_cnt)  cnt_q  <= wdata;
      if (wr_ctl)  ctl_q  <= wdata;
      else if (done) ctl_q[GO_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/dmac_irq.sv
module dmac_irq #(
  parameter int DW      = 32,
  parameter int NCH     = 7,
  parameter int IEN_LSB = 16,
  parameter int FLG_LSB = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_sel,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] done,
  output logic [DW-1:0]  icr_q,
  output logic           irq_req
);
  localparam int HIW = DW - FLG_LSB;

  logic [NCH-1:0] flag_set;
  logic [HIW-1:0] hi_next;
  logic [HIW-1:0] set_ext;

  always_comb begin
    flag_set = done & icr_q[IEN_LSB +: NCH];
    set_ext  = '0;
    set_ext[NCH-1:0] = flag_set;
    hi_next  = icr_q[DW-1:FLG_LSB];
    if (wr_sel) hi_next = hi_next & ~wdata[DW-1:FLG_LSB];
    hi_next  = hi_next | set_ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icr_q   <= '0;
      irq_req <= 1'b0;
    end else begin
      icr_q[DW-1:FLG_LSB] <= hi_next;
      if (wr_sel) icr_q[FLG_LSB-1:0] <= wdata[FLG_LSB-1:0];
      irq_req <= |flag_set;
    end
  end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NCH-1:0]   done_i,
  output logic             req_valid,
  output logic [CHW-1:0]   req_chan,
  output logic [DW-1:0]    req_addr,
  output logic [DW-1:0]    req_count,
  output logic             irq_req
);
  localparam logic [AW-1:0] BASE_A = AW'(CH_BASE);
  localparam logic [AW-1:0] GEN_A  = AW'(GEN_OFF);
  localparam logic [AW-1:0] ICR_A  = AW'(ICR_OFF);

  logic [DW-1:0]  addr_r [NCH];
  logic [DW-1:0]  cnt_r  [NCH];
  logic [DW-1:0]  ctl_r  [NCH];
  logic [NCH-1:0] start_v;
  logic [NCH-1:0] row_hit;
  logic [NCH-1:0] go_bits;
  logic [DW-1:0]  gen_q;
  logic [DW-1:0]  icr_q;
  slot_e          slot;
  logic           gen_hit, icr_hit;

  always_comb begin
    unique case (reg_addr[3:0])
      4'h0:    slot = SLOT_ADDR;
      4'h4:    slot = SLOT_CNT;
      4'h8:    slot = SLOT_CTL;
      default: slot = SLOT_NONE;
    endcase
  end

  assign gen_hit = (reg_addr == GEN_A);
  assign icr_hit = (reg_addr == ICR_A);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign row_hit[n] = (reg_addr[AW-1:4] == BASE_A[AW-1:4] + (AW-4)'(n));
    assign go_bits[n] = ctl_r[n][GO_BIT];
    dmac_chan #(.DW(DW), .GO_BIT(GO_BIT)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_addr (reg_we & row_hit[n] & (slot == SLOT_ADDR)),
      .wr_cnt  (reg_we & row_hit[n] & (slot == SLOT_CNT)),
      .wr_ctl  (reg_we & row_hit[n] & (slot == SLOT_CTL)),
      .wdata   (reg_wdata),
      .done    (done_i[n]),
      .chan_en (gen_q[3 + 4*n]),
      .addr_q  (addr_r[n]),
      .cnt_q   (cnt_r[n]),
      .ctl_q   (ctl_r[n]),
      .start   (start_v[n])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gen_q <= '0;
    else if (reg_we && gen_hit) gen_q <= reg_wdata;
  end

  dmac_irq #(.DW(DW), .NCH(NCH), .IEN_LSB(IEN_LSB), .FLG_LSB(FLG_LSB)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (reg_we & icr_hit),
    .wdata   (reg_wdata),
    .done    (done_i),
    .icr_q   (icr_q),
    .irq_req (irq_req)
  );

  // Only one register write per cycle, so at most one start bit is high.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_chan  <= '0;
      req_addr  <= '0;
      req_count <= '0;
    end else begin
      req_valid <= |start_v;
      for (int n = 0; n < NCH; n++) begin
        if (start_v[n]) begin
          req_chan  <= CHW'(n);
          req_addr  <= addr_r[n];
          req_count <= cnt_r[n];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (gen_hit) reg_rdata = gen_q;
    if (icr_hit) reg_rdata = icr_q;
    for (int n = 0; n < NCH; n++) begin
      if (row_hit[n]) begin
        case (slot)
          SLOT_ADDR: reg_rdata = addr_r[n];
          SLOT_CNT:  reg_rdata = cnt_r[n];
          SLOT_CTL:  reg_rdata = ctl_r[n];
          default:   reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmac_regs_chk.sv
module dmac_regs_chk
  import dmac_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           reg_we,
  input logic [AW-1:0]  reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic [NCH-1:0] done_i,
  input logic           req_valid,
  input logic [CHW-1:0] req_chan,
  input logic           irq_req,
  input logic [DW-1:0]  icr_q,
  input logic [NCH-1:0] go_bits
);
  // R3
  req_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(reg_we) && $past(reg_wdata[GO_BIT]));
  // R3
  req_chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_chan) < NCH));
  // R6
  irq_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(done_i) != '0));
  // R5
  done_clears_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && done_i != '0) |=> ((go_bits & $past(done_i)) == '0));
  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(ICR_OFF) && done_i == '0)
      |=> ((icr_q[DW-1:FLG_LSB] & $past(reg_wdata[DW-1:FLG_LSB])) == '0));
endmodule

bind dmac_regs dmac_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .done_i    (done_i),
  .req_valid (req_valid),
  .req_chan  (req_chan),
  .irq_req   (irq_req),
  .icr_q     (icr_q),
  .go_bits   (go_bits)
);

// File: tb/dmac_regs_tb.sv
`timescale 1ns/100ps
module dmac_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  done_i = '0;
  logic        req_valid;
  logic [2:0]  req_chan;
  logic [31:0] req_addr, req_count;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  dmac_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_i(done_i),
    .req_valid(req_valid), .req_chan(req_chan), .req_addr(req_addr),
    .req_count(req_count), .irq_req(irq_req)
  );

  // {addr, write data, expected readback}
  localparam int NV = 10;
  localparam logic [71:0] VEC [NV] = '{
    {8'h80, 32'hDEAD_0000, 32'hDEAD_0000},
    {8'h84, 32'h0000_0040, 32'h0000_0040},
    {8'hB0, 32'h0000_1234, 32'h0000_1234},
    {8'hB4, 32'h0000_0010, 32'h0000_0010},
    {8'hE0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {8'hE4, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {8'hF4, 32'hFFFF_FFFF, 32'h00FF_FFFF},
    {8'hF4, 32'h0000_0000, 32'h0000_0000},
    {8'hF0, 32'h1234_5678, 32'h1234_5678},
    {8'hF0, 32'h0888_8888, 32'h0888_8888}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_done(input logic [6:0] m);
    @(negedge clk);
    done_i = m;
    @(negedge clk);
    done_i = '0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h88, v);  chk("R1 ctl0", v, 0);
    rd(8'hF0, v);  chk("R1 gen", v, 0);
    rd(8'hF4, v);  chk("R1 icr", v, 0);
    chk("R1 req_valid", {31'd0, req_valid}, 0);
    chk("R1 irq_req", {31'd0, irq_req}, 0);

    // R2 / R8 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      chk("R2 no req on plain write", {31'd0, req_valid}, 0);
      rd(VEC[i][71:64], v);
      chk("R2 R8 readback", v, VEC[i][31:0]);
    end

    // R3 start with enable
    wr(8'hB8, 32'h0100_0201);
    chk("R3 req_valid", {31'd0, req_valid}, 1);
    chk("R3 req_chan", {29'd0, req_chan}, 3);
    chk("R3 req_addr", req_addr, 32'h0000_1234);
    chk("R3 req_count", req_count, 32'h0000_0010);
    @(negedge clk);
    chk("R3 single cycle", {31'd0, req_valid}, 0);
    rd(8'hB8, v); chk("R3 ctl stored", v, 32'h0100_0201);

    // R5 / R6 completion with interrupt enabled
    wr(8'hF4, 32'h0008_0000);
    pulse_done(7'b000_1000);
    chk("R6 irq pulse", {31'd0, irq_req}, 1);
    @(negedge clk);
    chk("R6 irq single cycle", {31'd0, irq_req}, 0);
    rd(8'hB8, v); chk("R5 go cleared", v, 32'h0000_0201);
    rd(8'hF4, v); chk("R6 flag set", v, 32'h0808_0000);

    // R8 write-one-to-clear
    wr(8'hF4, 32'h0808_0000);
    rd(8'hF4, v); chk("R8 w1c", v, 32'h0008_0000);

    // R4 start without enable
    wr(8'hF0, 32'h0888_8880);
    wr(8'h88, 32'h0100_0000);
    chk("R4 no req", {31'd0, req_valid}, 0);
    rd(8'h88, v); chk("R4 stored", v, 32'h0100_0000);

    // R7 completion without interrupt enable
    pulse_done(7'b000_0001);
    chk("R7 no irq", {31'd0, irq_req}, 0);
    rd(8'h88, v); chk("R7 R5 go cleared", v, 0);
    rd(8'hF4, v); chk("R7 no flag", v, 32'h0008_0000);

    // R9 completion and clear in same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'hF4; reg_wdata = 32'hFF08_0000; done_i = 7'b000_1000;
    @(negedge clk);
    reg_we = 1'b0; done_i = '0;
    chk("R9 irq", {31'd0, irq_req}, 1);
    rd(8'hF4, v); chk("R9 flag wins", v, 32'h0808_0000);

    // R11 control write and done in same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'hD8; reg_wdata = 32'h0100_0007; done_i = 7'b010_0000;
    @(negedge clk);
    reg_we = 1'b0; done_i = '0;
    chk("R11 req", {31'd0, req_valid}, 1);
    chk("R11 chan", {29'd0, req_chan}, 5);
    rd(8'hD8, v); chk("R11 write wins", v, 32'h0100_0007);

    // R10 unmapped
    rd(8'h00, v); chk("R10 0x00", v, 0);
    rd(8'h8C, v); chk("R10 0x8C", v, 0);
    rd(8'hF8, v); chk("R10 0xF8", v, 0);

    finish_run();
  end
endmodule